// File: doc/BRIEF.md
# Channel Command Bank

This block is the control-state front end of a multi-channel DMA controller. For every channel it holds a request-enable bit, an error-interrupt-enable bit, an interrupt-pending bit, an error-pending bit, a done flag and a start flag. The channel engine reads these bits on plain vector outputs. It reports completions and faults on per-channel pulse inputs.

Software never rewrites a whole vector. It writes one byte to a command port, and that byte changes the bits on its own. Each port applies one fixed operation, either set or clear, to one vector. The byte selects either a single channel or every channel, and it can also mark the write as a no-op. Several agents can therefore manage their own channels without a read-modify-write race. A register bus with byte writes and 32-bit combinational reads gives access to the vectors and the ports.

A channel is stopped in two steps: software first clears its pending interrupt, then clears its request enable.

Top module: `chan_cmd_bank`

## Requirements
- R1: Byte writes to offsets 0x18 to 0x1F act as commands. The operations are:
  - 0x18 sets request enable.
  - 0x19 clears request enable.
  - 0x1A sets error-interrupt enable.
  - 0x1B clears error-interrupt enable.
  - 0x1C clears interrupt pending.
  - 0x1D clears error pending.
  - 0x1E sets start.
  - 0x1F clears done.
- R2: Bits 4:0 of a command byte give the channel index, and only that channel's bit changes. Bit 5 is ignored.
- R3: When bit 6 of a command byte is 1, the operation applies to every channel and the index is ignored.
- R4: When bit 7 of a command byte is 1, the write has no effect, even if bit 6 is also 1.
- R5: Reads return 32-bit vectors where bit n belongs to channel n. The word offsets are:
  - 0x00: request enable.
  - 0x04: error-interrupt enable.
  - 0x08: interrupt pending.
  - 0x0C: error pending.
  - 0x10: done.
  - 0x14: start.
- R6: A completion pulse on a channel sets its interrupt-pending bit and its done bit. An error pulse sets its error-pending bit. If a pulse and a clear command hit the same bit in the same cycle, the bit ends up set.
- R7: A set-start command raises that channel's start output on the clock edge that accepts the write. The start output drops again on the following edge, so it lasts exactly one cycle.
- R8: A clear-done command clears only the selected done bit.
- R9: Reads of words 0x18 and 0x1C return zero. Writes to the vector offsets 0x00 to 0x17 change nothing.
- R10: `err_irq_o` is 1 exactly when some channel has both its error-pending bit and its error-interrupt-enable bit set.
- R11: After reset, every vector, the start output and `err_irq_o` are zero.
- R12: The stop sequence for a channel clears both its interrupt-pending bit and its request-enable bit. The bits of other channels are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| hw_done_i | input | 32 | Per-channel completion pulses |
| hw_err_i | input | 32 | Per-channel error pulses |
| req_en_o | output | 32 | Request-enable vector |
| err_int_en_o | output | 32 | Error-interrupt-enable vector |
| int_pend_o | output | 32 | Interrupt-pending vector |
| err_pend_o | output | 32 | Error-pending vector |
| done_o | output | 32 | Done vector |
| start_o | output | 32 | One-cycle start requests |
| err_irq_o | output | 1 | Combined error interrupt |

## Verification
The assertions assume that a write and a read never target the same address in the same cycle. They also assume that each hardware pulse input is a registered single-cycle strobe that is stable around the clock edge.

The stimulus changes every input only on the falling edge, and it drives no more than one bus strobe at a time. It includes a completion pulse that arrives in the same cycle as a clear command for the same bit, so that the set-wins rule is exercised on purpose.

// File: rtl/chan_cmd_pkg.sv
package chan_cmd_pkg;
  localparam int CMD_W    = 8;
  localparam int OP_COUNT = 8;
  localparam int IDX_W    = 5;
  localparam int ALL_BIT  = 6;
  localparam int NOP_BIT  = 7;

  // low three address bits of a command port pick the operation
  typedef enum logic [2:0] {
    OP_SET_REQ   = 3'd0,
    OP_CLR_REQ   = 3'd1,
    OP_SET_EIE   = 3'd2,
    OP_CLR_EIE   = 3'd3,
    OP_CLR_INT   = 3'd4,
    OP_CLR_ERR   = 3'd5,
    OP_SET_START = 3'd6,
    OP_CLR_DONE  = 3'd7
  } cmd_op_e;

  // word index (address bits 5:2) of readable vectors
  typedef enum logic [3:0] {
    RW_REQ   = 4'd0,
    RW_EIE   = 4'd1,
    RW_INT   = 4'd2,
    RW_ERR   = 4'd3,
    RW_DONE  = 4'd4,
    RW_START = 4'd5
  } rd_word_e;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import chan_cmd_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int ADDR_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [CMD_W-1:0]              wdata,
  output logic [OP_COUNT-1:0][NCH-1:0]  op_mask
);
  localparam logic [ADDR_W-4:0] CMD_PAGE = (ADDR_W-3)'(3);

  logic           hit;
  logic [2:0]     op;
  logic [IDX_W-1:0] idx;
  logic [NCH-1:0] sel;
  logic [OP_COUNT-1:0] ops_any;

  assign hit = wr && (addr[ADDR_W-1:3] == CMD_PAGE) && !wdata[NOP_BIT];
  assign op  = addr[2:0];
  assign idx = wdata[IDX_W-1:0];

  always_comb begin
    for (int i = 0; i < NCH; i++)
      sel[i] = wdata[ALL_BIT] || (idx == IDX_W'(i));
  end

  for (genvar g = 0; g < OP_COUNT; g++) begin : g_op
    assign op_mask[g]  = (hit && op == 3'(g)) ? sel : '0;
    assign ops_any[g]  = |op_mask[g];
  end

  // R1
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ops_any));
  // R4
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[NOP_BIT]) |-> (ops_any == '0));
endmodule

// File: rtl/flag_vec.sv
module flag_vec #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((q & $past(set)) == $past(set)));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set == '0 && clr == '0) |=> (q == $past(q)));
endmodule

// File: rtl/cmd_rd_mux.sv
module cmd_rd_mux
  import chan_cmd_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NCH-1:0]    v_req,
  input  logic [NCH-1:0]    v_eie,
  input  logic [NCH-1:0]    v_int,
  input  logic [NCH-1:0]    v_err,
  input  logic [NCH-1:0]    v_done,
  input  logic [NCH-1:0]    v_start,
  output logic [DATA_W-1:0] rdata
);
  logic [3:0] word;
  assign word = 4'(addr[ADDR_W-1:2]);

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (word)
        RW_REQ:   rdata = DATA_W'(v_req);
        RW_EIE:   rdata = DATA_W'(v_eie);
        RW_INT:   rdata = DATA_W'(v_int);
        RW_ERR:   rdata = DATA_W'(v_err);
        RW_DONE:  rdata = DATA_W'(v_done);
        RW_START: rdata = DATA_W'(v_start);
        default:  rdata = '0;
      endcase
    end
  end

  // R9
  cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr[ADDR_W-1:3] == (ADDR_W-3)'(3)) |-> (rdata == '0));
endmodule

// File: rtl/chan_cmd_bank.sv
module chan_cmd_bank
  import chan_cmd_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    hw_done_i,
  input  logic [NCH-1:0]    hw_err_i,
  output logic [NCH-1:0]    req_en_o,
  output logic [NCH-1:0]    err_int_en_o,
  output logic [NCH-1:0]    int_pend_o,
  output logic [NCH-1:0]    err_pend_o,
  output logic [NCH-1:0]    done_o,
  output logic [NCH-1:0]    start_o,
  output logic              err_irq_o
);
  logic [OP_COUNT-1:0][NCH-1:0] op_mask;

  cmd_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .op_mask(op_mask)
  );

  flag_vec #(.W(NCH)) u_req (.clk(clk), .rst_n(rst_n),
    .set(op_mask[OP_SET_REQ]), .clr(op_mask[OP_CLR_REQ]), .q(req_en_o));
  flag_vec #(.W(NCH)) u_eie (.clk(clk), .rst_n(rst_n),
    .set(op_mask[OP_SET_EIE]), .clr(op_mask[OP_CLR_EIE]), .q(err_int_en_o));
  flag_vec #(.W(NCH)) u_int (.clk(clk), .rst_n(rst_n),
    .set(hw_done_i), .clr(op_mask[OP_CLR_INT]), .q(int_pend_o));
  flag_vec #(.W(NCH)) u_err (.clk(clk), .rst_n(rst_n),
    .set(hw_err_i), .clr(op_mask[OP_CLR_ERR]), .q(err_pend_o));
  flag_vec #(.W(NCH)) u_done (.clk(clk), .rst_n(rst_n),
    .set(hw_done_i), .clr(op_mask[OP_CLR_DONE]), .q(done_o));
  // start flag is cleared by its own presentation one cycle later
  flag_vec #(.W(NCH)) u_start (.clk(clk), .rst_n(rst_n),
    .set(op_mask[OP_SET_START]), .clr(start_o), .q(start_o));

  assign err_irq_o = |(err_pend_o & err_int_en_o);

  cmd_rd_mux #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .addr(bus_addr),
    .v_req(req_en_o), .v_eie(err_int_en_o), .v_int(int_pend_o),
    .v_err(err_pend_o), .v_done(done_o), .v_start(start_o),
    .rdata(bus_rdata)
  );

  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mask[OP_SET_START] == '0) |=> (start_o == '0));
  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mask[OP_CLR_DONE] != '0 && hw_done_i == '0)
      |=> ((done_o & $past(op_mask[OP_CLR_DONE])) == '0));
endmodule

// File: tb/test_chan_cmd_bank.sv
module test_chan_cmd_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [5:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] hw_done_i = '0, hw_err_i = '0;
  logic [31:0] req_en_o, err_int_en_o, int_pend_o, err_pend_o, done_o, start_o;
  logic        err_irq_o;

  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  chan_cmd_bank i_chan_cmd_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_done_i(hw_done_i), .hw_err_i(hw_err_i), .req_en_o(req_en_o),
    .err_int_en_o(err_int_en_o), .int_pend_o(int_pend_o),
    .err_pend_o(err_pend_o), .done_o(done_o), .start_o(start_o),
    .err_irq_o(err_irq_o)
  );

  // behavioural reference: per-channel bits
  bit m_req[32], m_eie[32], m_int[32], m_err[32], m_done[32], m_start[32];

  function automatic logic [31:0] pack(input bit v[32]);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[i];
    return r;
  endfunction

  always @(posedge clk) begin
    bit hit;
    int op;
    hit = bus_wr && bus_addr >= 6'h18 && !bus_wdata[7];
    op  = bus_addr - 6'h18;
    for (int c = 0; c < 32; c++) begin
      bit sel;
      sel = hit && (bus_wdata[6] || bus_wdata[4:0] == c);
      if (!rst_n) begin
        m_req[c] = 0; m_eie[c] = 0; m_int[c] = 0;
        m_err[c] = 0; m_done[c] = 0; m_start[c] = 0;
      end else begin
        m_start[c] = sel && op == 6;
        if (sel && op == 0) m_req[c] = 1;
        if (sel && op == 1) m_req[c] = 0;
        if (sel && op == 2) m_eie[c] = 1;
        if (sel && op == 3) m_eie[c] = 0;
        if (sel && op == 4) m_int[c] = 0;
        if (sel && op == 5) m_err[c] = 0;
        if (sel && op == 7) m_done[c] = 0;
        if (hw_done_i[c]) begin m_int[c] = 1; m_done[c] = 1; end
        if (hw_err_i[c]) m_err[c] = 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the reference model (R5, R6, R10)
  always @(negedge clk) begin
    if (rst_n) begin
      logic any;
      any = 0;
      for (int i = 0; i < 32; i++) any |= m_err[i] & m_eie[i];
      chk("R5 model req", req_en_o, pack(m_req));
      chk("R5 model eie", err_int_en_o, pack(m_eie));
      chk("R6 model int", int_pend_o, pack(m_int));
      chk("R6 model err", err_pend_o, pack(m_err));
      chk("R8 model done", done_o, pack(m_done));
      chk("R7 model start", start_o, pack(m_start));
      chk("R10 model irq", 32'(err_irq_o), 32'(any));
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      finish_run();
    end
  end

  task automatic cmd(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1 v = bus_rdata;
    bus_rd = 0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11
    rd(6'h00, v); chk("R11 req after reset", v, 0);
    rd(6'h08, v); chk("R11 int after reset", v, 0);
    chk("R11 start after reset", start_o, 0);
    chk("R11 irq after reset", 32'(err_irq_o), 0);
    // R1 R2
    cmd(6'h18, 8'h03); rd(6'h00, v); chk("R2 set req ch3", v, 32'h8);
    // R3
    cmd(6'h18, 8'h40); rd(6'h00, v); chk("R3 set req all", v, 32'hFFFF_FFFF);
    // R4
    cmd(6'h19, 8'hC0); rd(6'h00, v); chk("R4 nop with all", v, 32'hFFFF_FFFF);
    cmd(6'h19, 8'h9F); rd(6'h00, v); chk("R4 nop with index", v, 32'hFFFF_FFFF);
    // R2 bit 5 ignored
    cmd(6'h19, 8'h20); rd(6'h00, v); chk("R2 clr req ch0 bit5", v, 32'hFFFF_FFFE);
    // R6
    @(negedge clk); hw_done_i = 32'h220;
    @(negedge clk); hw_done_i = 0;
    rd(6'h08, v); chk("R6 int from completion", v, 32'h220);
    rd(6'h10, v); chk("R6 done from completion", v, 32'h220);
    @(negedge clk); hw_err_i = 32'h4;
    @(negedge clk); hw_err_i = 0;
    rd(6'h0C, v); chk("R6 err from error pulse", v, 32'h4);
    // R10
    chk("R10 irq masked", 32'(err_irq_o), 0);
    cmd(6'h1A, 8'h02); chk("R10 irq enabled", 32'(err_irq_o), 1);
    rd(6'h04, v); chk("R5 eie vector", v, 32'h4);
    cmd(6'h1B, 8'h40); chk("R10 irq after clear all", 32'(err_irq_o), 0);
    // R6 set wins over clear in same cycle
    @(negedge clk); bus_wr = 1; bus_addr = 6'h1C; bus_wdata = 8'h05; hw_done_i = 32'h20;
    @(negedge clk); bus_wr = 0; hw_done_i = 0;
    rd(6'h08, v); chk("R6 set beats clear", v, 32'h220);
    // clears
    cmd(6'h1D, 8'h02); rd(6'h0C, v); chk("R6 clr err ch2", v, 0);
    // R7
    cmd(6'h1E, 8'h07); chk("R7 start raised", start_o, 32'h80);
    @(negedge clk); chk("R7 start dropped", start_o, 0);
    rd(6'h14, v); chk("R7 start read zero", v, 0);
    // R8
    cmd(6'h1F, 8'h09); rd(6'h10, v); chk("R8 clr done ch9", v, 32'h20);
    // R12 stop sequence on ch5
    cmd(6'h1C, 8'h05); cmd(6'h19, 8'h05);
    rd(6'h08, v); chk("R12 int cleared", v, 32'h200);
    rd(6'h00, v); chk("R12 req cleared", v, 32'hFFFF_FFDE);
    // R9
    cmd(6'h00, 8'h00); rd(6'h00, v); chk("R9 vector write ignored", v, 32'hFFFF_FFDE);
    rd(6'h18, v); chk("R9 cmd word read", v, 0);
    rd(6'h1C, v); chk("R9 cmd word read hi", v, 0);
    cmd(6'h1C, 8'h40); rd(6'h08, v); chk("R3 clr int all", v, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule